// File: doc/BRIEF.md
# Command-Driven Two-Wire EEPROM Master

This block is a byte-level master for a serial EEPROM on a two-wire bus with a clock line and a data line. Software never toggles the pins itself. It issues one bus primitive at a time by writing a 4-bit command into a control register. The primitives are: a start condition, a stop condition, sending one byte and collecting the device's acknowledge, receiving one byte and answering with an acknowledge, receiving a final byte with no acknowledge, and halting the bus clock. A separate 8-bit data register holds the byte to send, and it receives the byte read from the device.

A command is accepted only when the block is idle. BUSY stays high until the primitive has finished on the wire. When BUSY drops, a one-cycle interrupt pulse is raised. Once any primitive has started the serial clock, the clock keeps toggling between commands until the halt command stops it. Both bus lines are open-drain. The block drives them only low, through output enables, and external pull-ups supply the high level. The clock rate comes from a parameterised divider of the system clock. One bit slot lasts four quarter periods.

Top module: `twowire_eeprom_master`

## Requirements
- R1: The command field is control write data bits 3:0. The valid codes are 4'b1001 start, 4'b0011 send byte, 4'b0010 receive byte with acknowledge, 4'b0110 receive final byte without acknowledge, 4'b0101 stop, and 4'b0000 halt clock.
- R2: Writing any other code while idle sets ERROR (control bit 7). It starts no bus activity, leaves BUSY low and produces no interrupt.
- R3: The control read value is {ERROR, BUSY, RX_ACK, TX_ACK, 4'b0000}, with ERROR in bit 7, BUSY in bit 6, RX_ACK in bit 5 and TX_ACK in bit 4. After reset it reads 8'h30.
- R4: Send byte shifts the data register out MSB first over eight clock pulses and releases the data line on the ninth pulse. RX_ACK is then set to 1 if the line was low at that pulse's rising edge, and to 0 if it was high.
- R5: A receive command samples eight bits MSB first at the clock rising edges and places the byte in the data register by the time BUSY falls. On the ninth pulse it drives the data line low for 4'b0010 (TX_ACK becomes 1) or leaves it released for 4'b0110 (TX_ACK becomes 0).
- R6: BUSY is high from the cycle after a command is accepted until the primitive ends on the wire. The interrupt output is high for exactly one cycle, the first cycle in which BUSY is low again.
- R7: The serial clock period is 4*floor(CLK_HZ/(4*SCL_HZ)) system clocks. The clock line stays released after reset until a primitive starts it. It keeps toggling after primitives finish, including after stop, and the halt command releases it high.
- R8: Start pulls the data line low while the clock is high, and stop releases it while the clock is high. All other data line changes happen while the clock is low.
- R9: A control write while BUSY is high is ignored. It starts no primitive and does not change ERROR.
- R10: Accepting a valid command clears ERROR.
- R11: The bus outputs are active-high pull-down enables. After reset, neither line is pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Write strobe for the control register (command in wdata[3:0]) |
| data_wr | input | 1 | Write strobe for the data register |
| wdata | input | 8 | Host write data |
| ctl_rdata | output | 8 | Control/status read value |
| data_rdata | output | 8 | Data register read value |
| scl_oe | output | 1 | Pull clock line low when 1 |
| sda_oe | output | 1 | Pull data line low when 1 |
| sda_in | input | 1 | Sampled level of the data line |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions check several behaviours on every cycle. The data line may change under a high clock only during start and stop. The interrupt pulse is tied to the falling edge of BUSY and lasts one cycle. An illegal code raises ERROR without raising BUSY. Writes made while busy leave ERROR untouched. Other properties need a bus partner, so only the bench scenarios can show them. These are MSB-first order on the wire, the sampling of the device's acknowledge, the acknowledge driven after a read, the received byte landing in the data register, the measured clock period, the clock running on after stop, and the clock halting on the no-op command.

// File: rtl/tw_pkg.sv
package tw_pkg;
   typedef enum logic [3:0] {
      CMD_HALT   = 4'b0000,
      CMD_RDACK  = 4'b0010,
      CMD_WR     = 4'b0011,
      CMD_STOP   = 4'b0101,
      CMD_RDLAST = 4'b0110,
      CMD_START  = 4'b1001
   } tw_cmd_e;

   localparam int BIT_ERR   = 7;
   localparam int BIT_BUSY  = 6;
   localparam int BIT_RXACK = 5;
   localparam int BIT_TXACK = 4;
   localparam int SLOT_ACK  = 8;

   function automatic logic cmd_valid(input logic [3:0] c);
      return c == CMD_HALT || c == CMD_RDACK || c == CMD_WR ||
             c == CMD_STOP || c == CMD_RDLAST || c == CMD_START;
   endfunction
endpackage

// File: rtl/tw_tick.sv
module tw_tick #(
   parameter int QDIV = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   output logic       qtick,
   output logic [1:0] qph
);
   localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;

   if (QDIV < 1) begin : g_bad_div
      $error("tw_tick: QDIV must be at least 1");
   end

   if (QDIV == 1) begin : g_nodiv
      assign qtick = 1'b1;
   end else begin : g_div
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         cnt <= '0;
         else if (cnt == CW'(QDIV - 1))      cnt <= '0;
         else                                cnt <= cnt + 1'b1;
      end
      assign qtick = (cnt == CW'(QDIV - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     qph <= 2'd0;
      else if (qtick) qph <= qph + 2'd1;
   end
endmodule

// File: rtl/tw_bitseq.sv
module tw_bitseq
   import tw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       qtick,
   input  logic [1:0] qph,
   input  logic       go,
   input  tw_cmd_e    go_cmd,
   input  logic [7:0] tx_byte,
   input  logic       halt,
   input  logic       sda_in,
   output logic       busy,
   output logic       scl_oe,
   output logic       sda_oe,
   output logic [7:0] rx_byte,
   output logic       rx_ack,
   output logic       tx_ack,
   output logic       fin,
   output logic       rx_op,
   output logic       irq
);
   tw_cmd_e    op;
   logic       pend, active, running;
   logic [3:0] bitn, nx;
   logic [7:0] shreg;
   logic       sb, is_byte, last;

   assign sb      = qtick && (qph == 2'd3);
   assign is_byte = (op == CMD_WR) || (op == CMD_RDACK) || (op == CMD_RDLAST);
   assign rx_op   = (op == CMD_RDACK) || (op == CMD_RDLAST);
   assign last    = is_byte ? (bitn == 4'(SLOT_ACK)) : 1'b1;
   assign nx      = pend ? 4'd0 : bitn + 4'd1;
   assign fin     = sb && active && last;
   assign scl_oe  = running && !qph[1];
   assign rx_byte = shreg;

   function automatic logic slot_drive(input tw_cmd_e o, input logic [3:0] n,
                                       input logic [7:0] s);
      case (o)
         CMD_WR:    return (n == 4'(SLOT_ACK)) ? 1'b0 : ~s[3'd7 - n[2:0]];
         CMD_RDACK: return (n == 4'(SLOT_ACK));
         CMD_STOP:  return 1'b1;
         default:   return 1'b0;
      endcase
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op <= CMD_HALT;  pend <= 1'b0; active <= 1'b0; running <= 1'b0;
         busy <= 1'b0;    bitn <= 4'd0; shreg <= 8'h00; sda_oe <= 1'b0;
         rx_ack <= 1'b1;  tx_ack <= 1'b1; irq <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (halt) running <= 1'b0;
         if (go) begin
            busy <= 1'b1; pend <= 1'b1; op <= go_cmd; shreg <= tx_byte;
         end else if (sb && (pend || (active && !last))) begin
            pend   <= 1'b0;
            active <= 1'b1;
            bitn   <= nx;
            sda_oe <= slot_drive(op, nx, shreg);
            if (is_byte) running <= 1'b1;
         end else if (fin) begin
            active <= 1'b0;
            busy   <= 1'b0;
            irq    <= 1'b1;
            if (op == CMD_START) running <= 1'b1;
         end else if (qtick && active) begin
            if (qph == 2'd1) begin
               if (op == CMD_WR && bitn == 4'(SLOT_ACK)) rx_ack <= ~sda_in;
               if (rx_op && bitn < 4'(SLOT_ACK)) shreg <= {shreg[6:0], sda_in};
               if (rx_op && bitn == 4'(SLOT_ACK)) tx_ack <= (op == CMD_RDACK);
            end
            if (qph == 2'd2) begin
               if (op == CMD_START) sda_oe <= 1'b1;
               if (op == CMD_STOP)  sda_oe <= 1'b0;
            end
         end
      end
   end

   // R8: data moves under a high clock only inside start/stop primitives
   a_r8_sda_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
         |-> (op == CMD_START || op == CMD_STOP));
   // R6: interrupt accompanies every BUSY fall
   a_r6_irq_on_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> irq);
   // R6: interrupt is a single-cycle pulse
   a_r6_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   // R6: BUSY holds until the primitive finishes
   a_r6_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fin) |=> busy);
endmodule

// File: rtl/twowire_eeprom_master.sv
module twowire_eeprom_master
   import tw_pkg::*;
#(
   parameter int CLK_HZ = 5_000_000,
   parameter int SCL_HZ = 78_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_wr,
   input  logic       data_wr,
   input  logic [7:0] wdata,
   output logic [7:0] ctl_rdata,
   output logic [7:0] data_rdata,
   output logic       scl_oe,
   output logic       sda_oe,
   input  logic       sda_in,
   output logic       irq
);
   localparam int QDIV = CLK_HZ / (4 * SCL_HZ);

   if (SCL_HZ < 1 || QDIV < 1) begin : g_bad_rate
      $error("twowire_eeprom_master: SCL_HZ must be positive and at most CLK_HZ/4");
   end

   logic       qtick, busy, rx_ack, tx_ack, fin, rx_op;
   logic [1:0] qph;
   logic [7:0] rx_byte, dreg;
   logic       err, accept, valid, go, halt;

   assign valid  = cmd_valid(wdata[3:0]);
   assign accept = ctl_wr && !busy;
   assign go     = accept && valid && (wdata[3:0] != CMD_HALT);
   assign halt   = accept && (wdata[3:0] == CMD_HALT);

   tw_tick #(.QDIV(QDIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .qtick(qtick), .qph(qph)
   );

   tw_bitseq u_seq (
      .clk(clk), .rst_n(rst_n), .qtick(qtick), .qph(qph),
      .go(go), .go_cmd(tw_cmd_e'(wdata[3:0])), .tx_byte(dreg), .halt(halt),
      .sda_in(sda_in), .busy(busy), .scl_oe(scl_oe), .sda_oe(sda_oe),
      .rx_byte(rx_byte), .rx_ack(rx_ack), .tx_ack(tx_ack), .fin(fin),
      .rx_op(rx_op), .irq(irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      err <= 1'b0;
      else if (accept) err <= !valid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              dreg <= 8'h00;
      else if (data_wr)        dreg <= wdata;
      else if (fin && rx_op)   dreg <= rx_byte;
   end

   always_comb begin
      ctl_rdata            = 8'h00;
      ctl_rdata[BIT_ERR]   = err;
      ctl_rdata[BIT_BUSY]  = busy;
      ctl_rdata[BIT_RXACK] = rx_ack;
      ctl_rdata[BIT_TXACK] = tx_ack;
   end
   assign data_rdata = dreg;

   // R2: an illegal code flags ERROR and never starts a primitive
   a_r2_bad_code_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !busy && !valid) |=> (ctl_rdata[BIT_ERR] && !busy));
   // R9: writes during BUSY leave ERROR unchanged
   a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && busy) |=> $stable(ctl_rdata[BIT_ERR]));
   // R10: a valid accepted command clears ERROR
   a_r10_valid_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !busy && valid) |=> !ctl_rdata[BIT_ERR]);
endmodule

// File: tb/tb_twowire_eeprom_master.sv
module tb_twowire_eeprom_master;
   localparam int CLK_PER = 10;
   localparam int SLOT    = 64;

   logic clk = 1'b0, rst_n = 1'b0, ctl_wr = 1'b0, data_wr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] ctl_rdata, data_rdata;
   logic scl_oe, sda_oe, irq;
   logic slv_low = 1'b0;
   wire  scl_bus = ~scl_oe;
   wire  sda_bus = ~(sda_oe | slv_low);

   always #(CLK_PER/2) clk = ~clk;

   twowire_eeprom_master dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .data_wr(data_wr), .wdata(wdata),
      .ctl_rdata(ctl_rdata), .data_rdata(data_rdata), .scl_oe(scl_oe),
      .sda_oe(sda_oe), .sda_in(sda_bus), .irq(irq)
   );

   int vec = 0, miss = 0;
   int irq_cnt = 0, starts = 0, stops = 0, falls = 0, cyc = 0, last_fall = 0, period = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   // device model state
   logic       sl_act = 1'b0, sl_tx = 1'b0, sl_ack = 1'b0, ack_seen = 1'b0;
   logic [7:0] sl_byte = 8'h00, cap = 8'h00;
   int         sl_idx = 0;
   logic       p_scl = 1'b1, p_sda = 1'b1;

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      vec++;
      if (act !== exp) begin
         miss++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // bus monitor, device model and scoreboard, all away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (p_scl && scl_bus && p_sda && !sda_bus) starts++;
      if (p_scl && scl_bus && !p_sda && sda_bus) stops++;
      if (p_scl && !scl_bus) begin
         falls++;
         period = cyc - last_fall;
         last_fall = cyc;
         if (sl_act) begin
            if (sl_tx) slv_low <= (sl_idx == 8) && sl_ack;
            else       slv_low <= (sl_idx < 8) && !sl_byte[7 - (sl_idx % 8)];
            sl_idx++;
         end
      end
      if (!p_scl && scl_bus && sl_act) begin
         if (sl_idx >= 1 && sl_idx <= 8) cap <= {cap[6:0], sda_bus};
         if (sl_idx == 9) ack_seen <= !sda_bus;
      end
      p_scl <= scl_bus;
      p_sda <= sda_bus;
      if (irq) begin
         irq_cnt++;
         if (exp_q.size() == 0) begin
            vec++; miss++;
            $display("FAIL R6 actual=unexpected irq expected=none");
         end else begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({t, " ctl"}, ctl_rdata, e[15:8]);
            chk({t, " data"}, data_rdata, e[7:0]);
         end
      end
   end

   task automatic wr_ctl(input logic [3:0] c);
      @(negedge clk); ctl_wr = 1'b1; wdata = {4'h0, c};
      @(negedge clk); ctl_wr = 1'b0;
   endtask

   task automatic wr_data(input logic [7:0] v);
      @(negedge clk); data_wr = 1'b1; wdata = v;
      @(negedge clk); data_wr = 1'b0;
   endtask

   task automatic run_cmd(input logic [3:0] c, input logic [7:0] ectl,
                          input logic [7:0] edata, input string req);
      int n;
      n = irq_cnt;
      exp_q.push_back({ectl, edata});
      tag_q.push_back(req);
      wr_ctl(c);
      while (irq_cnt == n) @(negedge clk);
   endtask

   task automatic slave(input logic tx, input logic ack, input logic [7:0] b);
      sl_tx = tx; sl_ack = ack; sl_byte = b; sl_idx = 0; sl_act = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miss++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
   end

   initial begin
      int f0, n0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R3 reset value", ctl_rdata, 8'h30);
      chk("R11 no pull-down after reset", {6'd0, scl_oe, sda_oe}, 8'h00);
      f0 = falls;
      repeat (3*SLOT) @(negedge clk);
      chk("R7 clock rests high after reset", 8'(falls - f0), 8'd0);

      run_cmd(4'b1001, 8'h30, 8'h00, "R1 start");
      chk("R8 start condition seen", 8'(starts), 8'd1);

      wr_data(8'h3C); slave(1'b1, 1'b0, 8'h00);
      run_cmd(4'b0011, 8'h10, 8'h3C, "R4 send no-ack");
      chk("R4 msb-first 3C", cap, 8'h3C);

      wr_data(8'hA5); slave(1'b1, 1'b1, 8'h00);
      run_cmd(4'b0011, 8'h30, 8'hA5, "R4 send ack");
      chk("R4 msb-first A5", cap, 8'hA5);
      chk("R7 clock period", 8'(period), 8'(SLOT));

      slave(1'b0, 1'b0, 8'h96);
      run_cmd(4'b0010, 8'h30, 8'h96, "R5 receive ack");
      chk("R5 ack driven", {7'd0, ack_seen}, 8'h01);

      slave(1'b0, 1'b0, 8'h5A);
      run_cmd(4'b0110, 8'h20, 8'h5A, "R5 receive last");
      chk("R5 no ack driven", {7'd0, ack_seen}, 8'h00);

      sl_act = 1'b0; slv_low = 1'b0;
      run_cmd(4'b0101, 8'h20, 8'h5A, "R1 stop");
      chk("R8 stop condition seen", 8'(stops), 8'd1);
      f0 = falls;
      repeat (4*SLOT) @(negedge clk);
      chk("R7 clock runs after stop", {7'd0, (falls - f0) >= 3}, 8'h01);

      n0 = irq_cnt;
      wr_ctl(4'b0111);
      repeat (2) @(negedge clk);
      chk("R2 illegal code flags error", ctl_rdata, 8'hA0);
      repeat (2*SLOT) @(negedge clk);
      chk("R2 no completion for illegal code", 8'(irq_cnt - n0), 8'd0);

      wr_ctl(4'b0000);
      repeat (2) @(negedge clk);
      chk("R10 halt clears error", ctl_rdata, 8'h20);
      f0 = falls;
      repeat (3*SLOT) @(negedge clk);
      chk("R7 halt stops clock", 8'(falls - f0), 8'd0);
      chk("R7 clock released", {7'd0, scl_oe}, 8'h00);

      n0 = irq_cnt;
      exp_q.push_back({8'h20, 8'h5A});
      tag_q.push_back("R9 start with ignored writes");
      wr_ctl(4'b1001);
      chk("R6 busy after accept", ctl_rdata, 8'h60);
      wr_ctl(4'b1111);
      wr_ctl(4'b0011);
      chk("R9 error unchanged while busy", ctl_rdata, 8'h60);
      while (irq_cnt == n0) @(negedge clk);
      repeat (12*SLOT) @(negedge clk);
      chk("R9 single completion", 8'(irq_cnt - n0), 8'd1);
      chk("R8 second start seen", 8'(starts), 8'd2);

      $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
      $finish;
   end
endmodule